// File: doc/BRIEF.md
# Token-Bucket Meter Rate and Burst Encoder

This block turns a requested committed rate, in bits per second, and a bucket depth, in bytes, into the compact floating-point style settings that a hardware token-bucket meter expects. The bucket depth becomes an exponent and an 8-bit mantissa, so that the depth in bytes is (1 + mantissa/256)·2^exponent. The rate becomes an exponent, an 8-bit mantissa and a 4-bit time divider. The meter adds (1 + mantissa/256)·2^exponent bytes to the bucket once every 2·2^divider microseconds.

The rate is first scaled by 64, which accounts for the 2 µs meter tick and a fixed-point scale of one million. The scaled value is then brought into the window from 256,000,000 up to but not including 512,000,000. It is doubled one step per clock, counting the divider, or halved one step per clock, counting the exponent. The mantissa is the distance into the window divided by 1,000,000, and a multi-cycle restoring divider produces it.

A caller presents both inputs with a one-cycle `start`. It then waits for the one-cycle `done` pulse and reads all five fields together with a `fault` flag. The flag reports a rate too small to reach the window within the divider's range.

Top module: `meter_param_enc`

## Requirements
- R1: While and after synchronous reset, every output field, `fault`, `busy` and `done` are 0.
- R2: `burst_exp` is floor(log2(burst_bytes)), limited to at most 22; a burst of 0 gives 0.
- R3: When burst_bytes is below 256, `burst_man` is 0.
- R4: When burst_bytes is 256 or more, `burst_man` is (burst_bytes − 2^floor(log2 burst_bytes)) shifted right by (burst_exp − 8). A result above 255 reads as 255.
- R5: The working value starts at rate_bps·64. If it is below 256,000,000, it is doubled until it is at least 256,000,000. `rate_div` counts the doublings and `rate_exp` is 0.
- R6: Otherwise the working value is halved, rounding down, while it is at least 512,000,000 and the halving count is at most 22. `rate_exp` is that count, limited to 22, and `rate_div` is 0.
- R7: Without a fault, `rate_man` is (working value − 256,000,000)/1,000,000, rounded down. If the working value is still at or above 512,000,000, it reads 255.
- R8: If the divider reaches 15 and the working value is still below 256,000,000, the result has `fault` = 1, `rate_div` = 15, `rate_exp` = 0 and `rate_man` = 0.
- R9: `start` is taken only when `busy` is low, and `busy` is high in the cycle after a taken start. A `start` seen while `busy` is high has no effect on the result.
- R10: `done` is high for exactly one cycle per taken start. All output fields and `fault` change only in that cycle and hold their values at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of the present inputs |
| rate_bps | input | 64 | Committed rate in bits per second |
| burst_bytes | input | 32 | Bucket depth in bytes |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when new results appear |
| fault | output | 1 | Rate too small for the divider range |
| burst_exp | output | 5 | Bucket depth exponent |
| burst_man | output | 8 | Bucket depth mantissa |
| rate_exp | output | 5 | Rate exponent |
| rate_man | output | 8 | Rate mantissa |
| rate_div | output | 4 | Rate time divider |

## Verification
The hardest region to reach is the edge of the divider range. There, 15 doublings either just reach the window or just fall short: rates of 122 and 123 bits per second lie on opposite sides. The other hard region is the far end of the halving path, where the exponent clamps while the working value is still above the window. The stimulus names these rates directly. It also feeds a shifted pseudo-random sequence whose shift amount spreads rates across all 64 bit positions, so every doubling and halving count is visited. Bucket depths are swept exhaustively over the low range and at every power of two and its neighbours. A second start is injected in mid-conversion to show that it is ignored.

// File: rtl/meter_enc_pkg.sv
package meter_enc_pkg;

    localparam int RATE_W    = 64;
    localparam int BURST_W   = 32;
    localparam int EXP_W     = 5;
    localparam int MAN_W     = 8;
    localparam int RDIV_W    = 4;
    localparam int EXP_LIMIT = 22;
    localparam int PRE_SHIFT = 6;
    localparam int WORK_W    = RATE_W + PRE_SHIFT;

    localparam longint unsigned WIN_LO    = 64'd256_000_000;
    localparam longint unsigned WIN_HI    = 64'd512_000_000;
    localparam longint unsigned STEP_UNIT = 64'd1_000_000;

    // window offset is below WIN_HI - WIN_LO < 2^28, unit below 2^20
    localparam int OFFS_W = 28;
    localparam int UNIT_W = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_DIV
    } enc_state_e;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } burst_cfg_t;

    typedef struct packed {
        logic [EXP_W-1:0]  exp;
        logic [MAN_W-1:0]  man;
        logic [RDIV_W-1:0] rdiv;
        logic              fault;
    } rate_cfg_t;

    function automatic logic [MAN_W-1:0] sat_man(input logic [OFFS_W-1:0] q);
        logic [MAN_W-1:0] r;
        if (|q[OFFS_W-1:MAN_W]) r = '1;
        else                    r = q[MAN_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/meter_burst_enc.sv
module meter_burst_enc
    import meter_enc_pkg::*;
#(
    parameter int BW      = BURST_W,
    parameter int EXP_CAP = EXP_LIMIT
) (
    input  logic [BW-1:0] burst_i,
    output burst_cfg_t    cfg_o
);

    int          lead;
    int          capped;
    logic [BW-1:0] rem;
    logic [BW-1:0] shifted;

    always_comb begin
        lead = 0;
        for (int i = 0; i < BW; i++) begin
            if (burst_i[i]) lead = i;
        end
        rem     = burst_i & ~(BW'(1) << lead);
        capped  = (lead > EXP_CAP) ? EXP_CAP : lead;
        shifted = '0;
        cfg_o   = '0;
        if (burst_i < BW'(256)) begin
            cfg_o.exp = EXP_W'(lead);
            cfg_o.man = '0;
        end else begin
            shifted   = rem >> (capped - MAN_W);
            cfg_o.exp = EXP_W'(capped);
            cfg_o.man = (|shifted[BW-1:MAN_W]) ? '1 : shifted[MAN_W-1:0];
        end
    end

endmodule

// File: rtl/meter_rate_norm.sv
module meter_rate_norm
    import meter_enc_pkg::*;
#(
    parameter int RW   = RATE_W,
    parameter int WW   = RW + PRE_SHIFT,
    parameter int EW   = EXP_W,
    parameter int DW   = RDIV_W,
    parameter int ECAP = EXP_LIMIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [RW-1:0] rate_i,
    output logic          fin_o,
    output logic          fault_o,
    output logic [WW-1:0] work_o,
    output logic [EW-1:0] exp_o,
    output logic [DW-1:0] rdiv_o
);

    localparam logic [WW-1:0] LO       = WW'(WIN_LO);
    localparam logic [WW-1:0] HI       = WW'(WIN_HI);
    localparam logic [DW-1:0] DIV_TOP  = '1;
    localparam logic [EW-1:0] EXP_STOP = EW'(ECAP);

    logic          run_q;
    logic          up_q;
    logic [WW-1:0] seed;

    assign seed = WW'({rate_i, {PRE_SHIFT{1'b0}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            up_q    <= 1'b0;
            fin_o   <= 1'b0;
            fault_o <= 1'b0;
            work_o  <= '0;
            exp_o   <= '0;
            rdiv_o  <= '0;
        end else begin
            fin_o <= 1'b0;
            if (load_i) begin
                work_o  <= seed;
                exp_o   <= '0;
                rdiv_o  <= '0;
                fault_o <= 1'b0;
                run_q   <= 1'b1;
                up_q    <= (seed < LO);
            end else if (run_q) begin
                if (up_q) begin
                    if (work_o >= LO) begin
                        run_q <= 1'b0;
                        fin_o <= 1'b1;
                    end else if (rdiv_o == DIV_TOP) begin
                        run_q   <= 1'b0;
                        fin_o   <= 1'b1;
                        fault_o <= 1'b1;
                    end else begin
                        work_o <= work_o << 1;
                        rdiv_o <= rdiv_o + DW'(1);
                    end
                end else begin
                    if (work_o >= HI && exp_o <= EXP_STOP) begin
                        work_o <= work_o >> 1;
                        exp_o  <= exp_o + EW'(1);
                    end else begin
                        run_q <= 1'b0;
                        fin_o <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/meter_div_restore.sv
module meter_div_restore
    import meter_enc_pkg::*;
#(
    parameter int NW  = OFFS_W,
    parameter int DVW = UNIT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go_i,
    input  logic [NW-1:0]  num_i,
    input  logic [DVW-1:0] den_i,
    output logic           fin_o,
    output logic [NW-1:0]  quo_o
);

    localparam int CW = $clog2(NW + 1);

    logic [DVW-1:0] acc_q;
    logic [DVW-1:0] den_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic [DVW:0]   trial;
    logic [DVW:0]   diff;
    logic           take;

    always_comb begin
        trial = {acc_q, quo_o[NW-1]};
        diff  = trial - {1'b0, den_q};
        take  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_o <= 1'b0;
            quo_o <= '0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                acc_q <= '0;
                den_q <= den_i;
                quo_o <= num_i;
                cnt_q <= CW'(NW);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (take) acc_q <= diff[DVW-1:0];
                else      acc_q <= trial[DVW-1:0];
                quo_o <= {quo_o[NW-2:0], take};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/meter_param_enc.sv
module meter_param_enc
    import meter_enc_pkg::*;
#(
    parameter int EXP_CAP = EXP_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_bps,
    input  logic [BURST_W-1:0] burst_bytes,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [EXP_W-1:0]  burst_exp,
    output logic [MAN_W-1:0]  burst_man,
    output logic [EXP_W-1:0]  rate_exp,
    output logic [MAN_W-1:0]  rate_man,
    output logic [RDIV_W-1:0] rate_div
);

    localparam logic [WORK_W-1:0] W_LO  = WORK_W'(WIN_LO);
    localparam logic [WORK_W-1:0] W_HI  = WORK_W'(WIN_HI);
    localparam logic [EXP_W-1:0]  E_CAP = EXP_W'(EXP_CAP);

    enc_state_e        st_q;
    burst_cfg_t        burst_now;
    burst_cfg_t        burst_hold_q;
    rate_cfg_t         rate_nx;
    logic              accept;
    logic              publish;

    logic              norm_fin;
    logic              norm_fault;
    logic [WORK_W-1:0] norm_work;
    logic [EXP_W-1:0]  norm_exp;
    logic [RDIV_W-1:0] norm_rdiv;
    logic [EXP_W-1:0]  exp_capped;
    logic              over_win;

    logic              div_go;
    logic [OFFS_W-1:0] div_num;
    logic              div_fin;
    logic [OFFS_W-1:0] div_quo;

    assign accept     = start && (st_q == ST_IDLE);
    assign busy       = (st_q != ST_IDLE);
    assign over_win   = (norm_work >= W_HI);
    assign exp_capped = (norm_exp > E_CAP) ? E_CAP : norm_exp;
    assign div_go     = (st_q == ST_NORM) && norm_fin && !norm_fault && !over_win;
    assign div_num    = OFFS_W'(norm_work - W_LO);

    meter_burst_enc #(
        .BW      (BURST_W),
        .EXP_CAP (EXP_CAP)
    ) u_burst (
        .burst_i (burst_bytes),
        .cfg_o   (burst_now)
    );

    meter_rate_norm #(
        .RW   (RATE_W),
        .WW   (WORK_W),
        .EW   (EXP_W),
        .DW   (RDIV_W),
        .ECAP (EXP_CAP)
    ) u_norm (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .rate_i  (rate_bps),
        .fin_o   (norm_fin),
        .fault_o (norm_fault),
        .work_o  (norm_work),
        .exp_o   (norm_exp),
        .rdiv_o  (norm_rdiv)
    );

    meter_div_restore #(
        .NW  (OFFS_W),
        .DVW (UNIT_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .go_i  (div_go),
        .num_i (div_num),
        .den_i (UNIT_W'(STEP_UNIT)),
        .fin_o (div_fin),
        .quo_o (div_quo)
    );

    always_comb begin
        publish = 1'b0;
        rate_nx = '0;
        case (st_q)
            ST_NORM: begin
                if (norm_fin && (norm_fault || over_win)) begin
                    publish       = 1'b1;
                    rate_nx.exp   = exp_capped;
                    rate_nx.man   = norm_fault ? '0 : '1;
                    rate_nx.rdiv  = norm_rdiv;
                    rate_nx.fault = norm_fault;
                end
            end
            ST_DIV: begin
                if (div_fin) begin
                    publish       = 1'b1;
                    rate_nx.exp   = exp_capped;
                    rate_nx.man   = sat_man(div_quo);
                    rate_nx.rdiv  = norm_rdiv;
                    rate_nx.fault = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            burst_hold_q <= '0;
            done         <= 1'b0;
            fault        <= 1'b0;
            burst_exp    <= '0;
            burst_man    <= '0;
            rate_exp     <= '0;
            rate_man     <= '0;
            rate_div     <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        burst_hold_q <= burst_now;
                        st_q         <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (div_go) st_q <= ST_DIV;
                end
                default: ;
            endcase
            if (publish) begin
                st_q      <= ST_IDLE;
                done      <= 1'b1;
                burst_exp <= burst_hold_q.exp;
                burst_man <= burst_hold_q.man;
                rate_exp  <= rate_nx.exp;
                rate_man  <= rate_nx.man;
                rate_div  <= rate_nx.rdiv;
                fault     <= rate_nx.fault;
            end
        end
    end

endmodule

// File: rtl/meter_param_enc_chk.sv
module meter_param_enc_chk
    import meter_enc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [EXP_W-1:0]  burst_exp,
    input logic [MAN_W-1:0]  burst_man,
    input logic [EXP_W-1:0]  rate_exp,
    input logic [MAN_W-1:0]  rate_man,
    input logic [RDIV_W-1:0] rate_div
);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(burst_exp) && $stable(burst_man) && $stable(rate_exp)
                   && $stable(rate_man) && $stable(rate_div) && $stable(fault)));

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_burst_exp_cap_R2: assert property (@(posedge clk) disable iff (rst)
        burst_exp <= EXP_W'(EXP_LIMIT));

    assert_rate_exp_cap_R6: assert property (@(posedge clk) disable iff (rst)
        rate_exp <= EXP_W'(EXP_LIMIT));

    assert_one_direction_R5: assert property (@(posedge clk) disable iff (rst)
        (rate_exp != '0) |-> (rate_div == '0));

    assert_fault_fields_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rate_div == '1 && rate_man == '0 && rate_exp == '0));

endmodule

bind meter_param_enc meter_param_enc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .burst_exp (burst_exp),
    .burst_man (burst_man),
    .rate_exp  (rate_exp),
    .rate_man  (rate_man),
    .rate_div  (rate_div)
);

// File: tb/meter_param_enc_tb_top.sv
module meter_param_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] rate_bps = '0;
    logic [31:0] burst_bytes = '0;
    logic        busy, done, fault;
    logic [4:0]  burst_exp, rate_exp;
    logic [7:0]  burst_man, rate_man;
    logic [3:0]  rate_div;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    // last published values, for the hold checks
    logic [4:0] h_bexp, h_rexp;
    logic [7:0] h_bman, h_rman;
    logic [3:0] h_rdiv;
    logic       h_flt;

    always #2.5 clk = ~clk;

    meter_param_enc dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .rate_bps    (rate_bps),
        .burst_bytes (burst_bytes),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .burst_exp   (burst_exp),
        .burst_man   (burst_man),
        .rate_exp    (rate_exp),
        .rate_man    (rate_man),
        .rate_div    (rate_div)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000 && !finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic model(input logic [63:0] r, input logic [31:0] b,
                         output int be, output int bm, output int re,
                         output int rm, output int rd, output int fl);
        logic [79:0] t;
        logic [31:0] q;
        int lead;
        lead = 0;
        for (int i = 0; i < 32; i++) if (b[i]) lead = i;
        if (b < 256) begin
            be = lead; bm = 0;
        end else begin
            be = (lead > 22) ? 22 : lead;
            q  = (b - (32'd1 << lead)) >> (be - 8);
            bm = (q > 255) ? 255 : int'(q);
        end
        t = {16'b0, r} << 6;
        re = 0; rd = 0; fl = 0;
        if (t < 80'd256_000_000) begin
            while (t < 80'd256_000_000) begin
                if (rd == 15) begin fl = 1; break; end
                t = t * 2;
                rd++;
            end
        end else begin
            while (t >= 80'd512_000_000 && re <= 22) begin
                t = t / 2;
                re++;
            end
            if (re > 22) re = 22;
        end
        if (fl)                         rm = 0;
        else if (t >= 80'd512_000_000)  rm = 255;
        else                            rm = int'((t - 80'd256_000_000) / 80'd1_000_000);
    endtask

    task automatic run_one(input logic [63:0] r, input logic [31:0] b, input bit poke);
        int be, bm, re, rm, rd, fl;
        int wait_n;
        model(r, b, be, bm, re, rm, rd, fl);
        @(negedge clk);
        while (busy) @(negedge clk);
        rate_bps = r; burst_bytes = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", busy, 1);
        wait_n = 0;
        while (!done && wait_n < 200) begin
            if (poke && wait_n == 1) begin
                rate_bps = ~r; burst_bytes = ~b; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (wait_n > 0) begin
                chk("R10 hold while busy", {h_bexp, h_bman, h_rexp, h_rman, h_rdiv, h_flt},
                    {burst_exp, burst_man, rate_exp, rate_man, rate_div, fault});
            end
            @(negedge clk);
            wait_n++;
        end
        start = 1'b0;
        chk("R10 done reached", done, 1);
        chk("R2 burst_exp", burst_exp, be);
        if (b < 256) chk("R3 burst_man small", burst_man, bm);
        else         chk("R4 burst_man", burst_man, bm);
        if (rd > 0)  chk("R5 rate_div", rate_div, rd);
        else         chk("R6 rate_div zero", rate_div, rd);
        chk("R6 rate_exp", rate_exp, re);
        chk("R7 rate_man", rate_man, rm);
        chk("R8 fault", fault, fl);
        if (poke) chk("R9 ignored start", {rate_exp, rate_man, rate_div, burst_exp},
                      {5'(re), 8'(rm), 4'(rd), 5'(be)});
        h_bexp = burst_exp; h_bman = burst_man; h_rexp = rate_exp;
        h_rman = rate_man;  h_rdiv = rate_div;  h_flt  = fault;
        @(negedge clk);
        chk("R10 done one cycle", done, 0);
        chk("R10 hold after done", {h_bexp, h_bman, h_rexp, h_rman, h_rdiv, h_flt},
            {burst_exp, burst_man, rate_exp, rate_man, rate_div, fault});
    endtask

    initial begin
        logic [63:0] x;
        repeat (4) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset fields", {burst_exp, burst_man, rate_exp, rate_man, rate_div, fault}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {busy, done, burst_exp, burst_man, rate_exp, rate_man, rate_div, fault}, 0);
        h_bexp = '0; h_bman = '0; h_rexp = '0; h_rman = '0; h_rdiv = '0; h_flt = 1'b0;

        // named corner rates (R5 R6 R7 R8)
        run_one(64'd0,             32'd0,          0);
        run_one(64'd1,             32'd1,          0);
        run_one(64'd122,           32'd255,        0);
        run_one(64'd123,           32'd256,        1);
        run_one(64'd124,           32'd257,        0);
        run_one(64'd3_999_999,     32'd384,        0);
        run_one(64'd4_000_000,     32'd511,        1);
        run_one(64'd4_000_001,     32'd512,        0);
        run_one(64'd7_999_999,     32'd1000,       0);
        run_one(64'd8_000_000,     32'd65535,      0);
        run_one(64'd1_000_000_000, 32'h00C0_0000,  1);
        run_one(64'd100_000_000_000, 32'h0080_0000, 0);
        run_one(64'h0000_0001_0000_0000, 32'h0180_0000, 0);
        run_one(64'h8000_0000_0000_0000, 32'hFFFF_FFFF, 1);
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000, 0);

        // bucket depth at every power of two and its neighbours (R2 R4)
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 32; k++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            run_one(x >> x[5:0], 32'd1 << k, 0);
            run_one(x >> x[11:6], (32'd1 << k) - 32'd1, 0);
            run_one(x, (32'd1 << k) | (32'd1 << (k > 0 ? k - 1 : 0)), 0);
        end

        // exhaustive low bucket sweep, rates spread over all magnitudes
        for (int b = 0; b < 768; b++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            run_one(x >> x[5:0], 32'(b), (b % 97) == 5);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule